// File: doc/BRIEF.md
# Pixel Word Packer

This block sits at the end of a video conditioning pipeline, just in front of a FIFO write port. Each input word carries four 16-bit pixel slots, with slot 0 in the low bits. The block repacks those pixels into dense 64-bit words for the FIFO. The packing width follows a one-bit depth setting. A display control overrides that setting and always packs one byte per pixel. In byte mode the low byte of every slot is used. This assumes that the upstream shifter has already moved the significant bits down: a 10-bit camera, for example, needs a 2-bit right shift.

For cameras that interleave odd and even pixels, a swap control exchanges adjacent slots before packing: slot 0 with slot 1, and slot 2 with slot 3. An end-of-line strobe flushes a half-filled output word with its unused bytes zeroed. The same strobe re-aligns the packing phase, so that every line starts on a fresh output word. Each output word is presented for one cycle with a write strobe, one clock after the input that completes it.

Top module: `pxpk_assembler`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `fifo_wr` is 0. Reset clears the packing phase, so the first byte-mode word after reset lands in bits 31:0.
- R2: In word mode (`cfg_depth`=1, `cfg_display`=0, `cfg_swap`=0), every input word with `pix_valid` gives `fifo_wr`=1 in the next cycle, and `fifo_data` is equal to that input word.
- R3: In byte mode (`cfg_depth`=0), two consecutive valid words produce one output word. Byte k of the first word's output half, bits 8k+7:8k, is bits 7:0 of input slot k. The second word fills bits 32+8k+7:32+8k in the same way. The upper byte of each slot is discarded.
- R4: In byte mode, a valid word that starts a new output word without `pix_eol` produces no write.
- R5: `cfg_display`=1 selects byte mode even when `cfg_depth`=1.
- R6: `cfg_swap`=1 exchanges slot 0 with slot 1 and slot 2 with slot 3 of each input word before packing. This applies in both modes.
- R7: When `pix_eol` comes with a valid byte-mode word that starts an output word, that word is written at once, with bits 63:32 zero. When `pix_eol` comes with a word that completes an output word, the full word is written.
- R8: When `pix_eol` comes without `pix_valid` and a half word is pending, the half word is written with bits 63:32 zero. When nothing is pending, nothing is written.
- R9: After any end of line, the next byte-mode word starts a new output word in bits 31:0.
- R10: `fifo_wr` is high only in the cycle after `pix_valid` or `pix_eol` was high. An idle cycle writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Input word is valid |
| pix_eol | input | 1 | End-of-line strobe (flush and phase realign) |
| pix_data | input | 64 | Four 16-bit pixel slots, slot 0 in bits 15:0 |
| cfg_depth | input | 1 | 0 = byte pixels, 1 = 16-bit pixels |
| cfg_display | input | 1 | Forces byte packing when 1 |
| cfg_swap | input | 1 | Exchanges adjacent slot pairs when 1 |
| fifo_wr | output | 1 | Write strobe for the packed word |
| fifo_data | output | 64 | Packed output word |

## Verification
On every cycle the assertions check the following:
- Writes only follow an input or an end-of-line event.
- Word mode is a one-cycle pass-through, and applies the pair swap when it is selected.
- A write in byte mode caused by a word without end of line carries that word's low slot bytes in the upper half.
- Flushes caused by end of line alone keep the upper half zero.

These properties cannot tell which half a given byte-mode word lands in, because that depends on the packing phase. Only the bench's scenarios show that the phase starts at zero after reset, returns to zero after each end of line, and stays silent on the first half of a pair. The bench checks this with known sequences of words.

// File: rtl/pxpk_pkg.sv
package pxpk_pkg;

    localparam int SLOT_W  = 16;
    localparam int N_SLOTS = 4;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = SLOT_W * N_SLOTS;
    localparam int HALF_W  = BYTE_W * N_SLOTS;

    typedef enum logic {
        DEPTH_8  = 1'b0,
        DEPTH_16 = 1'b1
    } depth_e;

    typedef struct packed {
        logic              valid;
        logic              eol;
        logic              mode8;
        logic [WORD_W-1:0] word;
        logic [HALF_W-1:0] bytes;
    } stage_t;

    // Exchange slot pairs (0<->1, 2<->3, ...)
    function automatic logic [WORD_W-1:0] swap_pairs(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int p = 0; p < N_SLOTS / 2; p++) begin
            r[(2*p)*SLOT_W +: SLOT_W]   = w[(2*p+1)*SLOT_W +: SLOT_W];
            r[(2*p+1)*SLOT_W +: SLOT_W] = w[(2*p)*SLOT_W +: SLOT_W];
        end
        return r;
    endfunction

    // Gather the low byte of every slot, slot k -> byte k
    function automatic logic [HALF_W-1:0] low_bytes(input logic [WORD_W-1:0] w);
        logic [HALF_W-1:0] r;
        for (int k = 0; k < N_SLOTS; k++) begin
            r[k*BYTE_W +: BYTE_W] = w[k*SLOT_W +: BYTE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/pxpk_swap.sv
module pxpk_swap
    import pxpk_pkg::*;
#(
    parameter int SW = SLOT_W,
    parameter int NS = N_SLOTS
) (
    input  logic           en,
    input  logic [SW*NS-1:0] din,
    output logic [SW*NS-1:0] dout
);
    localparam int NPAIRS = NS / 2;

    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
        logic [SW-1:0] even_s;
        logic [SW-1:0] odd_s;
        assign even_s = din[(2*p)*SW +: SW];
        assign odd_s  = din[(2*p+1)*SW +: SW];
        assign dout[(2*p)*SW +: SW]   = en ? odd_s  : even_s;
        assign dout[(2*p+1)*SW +: SW] = en ? even_s : odd_s;
    end
endmodule

// File: rtl/pxpk_mode.sv
module pxpk_mode
    import pxpk_pkg::*;
(
    input  logic              valid,
    input  logic              eol,
    input  logic              depth,
    input  logic              display,
    input  logic [WORD_W-1:0] word,
    output stage_t            stage
);
    depth_e eff_depth;

    always_comb begin
        eff_depth   = display ? DEPTH_8 : depth_e'(depth);
        stage.valid = valid;
        stage.eol   = eol;
        stage.mode8 = (eff_depth == DEPTH_8);
        stage.word  = word;
        stage.bytes = low_bytes(word);
    end
endmodule

// File: rtl/pxpk_pack.sv
module pxpk_pack
    import pxpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stage_t            stage,
    output logic              wr,
    output logic [WORD_W-1:0] data
);
    localparam logic [HALF_W-1:0] ZERO_HALF = '0;

    logic              phase_q, phase_d;
    logic [HALF_W-1:0] hold_q, hold_d;
    logic              wr_d;
    logic [WORD_W-1:0] data_d;

    always_comb begin
        phase_d = phase_q;
        hold_d  = hold_q;
        wr_d    = 1'b0;
        data_d  = data;
        if (stage.valid) begin
            if (!stage.mode8) begin
                wr_d    = 1'b1;
                data_d  = stage.word;
                phase_d = 1'b0;
            end else if (!phase_q) begin
                if (stage.eol) begin
                    wr_d   = 1'b1;
                    data_d = {ZERO_HALF, stage.bytes};
                end else begin
                    hold_d  = stage.bytes;
                    phase_d = 1'b1;
                end
            end else begin
                wr_d    = 1'b1;
                data_d  = {stage.bytes, hold_q};
                phase_d = 1'b0;
            end
        end else if (stage.eol && phase_q) begin
            wr_d    = 1'b1;
            data_d  = {ZERO_HALF, hold_q};
            phase_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            hold_q  <= '0;
            wr      <= 1'b0;
            data    <= '0;
        end else begin
            phase_q <= phase_d;
            hold_q  <= hold_d;
            wr      <= wr_d;
            data    <= data_d;
        end
    end
endmodule

// File: rtl/pxpk_assembler.sv
module pxpk_assembler
    import pxpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_valid,
    input  logic              pix_eol,
    input  logic [WORD_W-1:0] pix_data,
    input  logic              cfg_depth,
    input  logic              cfg_display,
    input  logic              cfg_swap,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data
);
    logic [WORD_W-1:0] swapped;
    stage_t            stage;

    pxpk_swap #(.SW(SLOT_W), .NS(N_SLOTS)) u_swap (
        .en   (cfg_swap),
        .din  (pix_data),
        .dout (swapped)
    );

    pxpk_mode u_mode (
        .valid   (pix_valid),
        .eol     (pix_eol),
        .depth   (cfg_depth),
        .display (cfg_display),
        .word    (swapped),
        .stage   (stage)
    );

    pxpk_pack u_pack (
        .clk   (clk),
        .rst   (rst),
        .stage (stage),
        .wr    (fifo_wr),
        .data  (fifo_data)
    );
endmodule

// File: rtl/pxpk_assembler_chk.sv
module pxpk_assembler_chk
    import pxpk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pix_valid,
    input logic              pix_eol,
    input logic [WORD_W-1:0] pix_data,
    input logic              cfg_depth,
    input logic              cfg_display,
    input logic              cfg_swap,
    input logic              fifo_wr,
    input logic [WORD_W-1:0] fifo_data
);
    logic word_mode;
    logic [WORD_W-1:0] in_sw;
    assign word_mode = cfg_depth && !cfg_display;
    assign in_sw     = cfg_swap ? swap_pairs(pix_data) : pix_data;

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !fifo_wr);

    p_wr_cause_r10: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> $past(pix_valid || pix_eol));

    p_word_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && word_mode && !cfg_swap) |=> (fifo_wr && fifo_data == $past(pix_data)));

    p_word_swap_r6: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && word_mode && cfg_swap) |=>
            (fifo_wr && fifo_data == swap_pairs($past(pix_data))));

    p_byte_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !word_mode && !pix_eol) |=>
            (!fifo_wr || fifo_data[WORD_W-1:HALF_W] == low_bytes($past(in_sw))));

    p_eol_emits_r7: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_eol) |=> fifo_wr);

    p_flush_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (pix_eol && !pix_valid) |=> (!fifo_wr || fifo_data[WORD_W-1:HALF_W] == '0));
endmodule

bind pxpk_assembler pxpk_assembler_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pix_valid   (pix_valid),
    .pix_eol     (pix_eol),
    .pix_data    (pix_data),
    .cfg_depth   (cfg_depth),
    .cfg_display (cfg_display),
    .cfg_swap    (cfg_swap),
    .fifo_wr     (fifo_wr),
    .fifo_data   (fifo_data)
);

// File: tb/pxpk_assembler_bench.sv
`timescale 1ns/1ps
module pxpk_assembler_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_valid = 1'b0;
    logic        pix_eol = 1'b0;
    logic [63:0] pix_data = '0;
    logic        cfg_depth = 1'b0;
    logic        cfg_display = 1'b0;
    logic        cfg_swap = 1'b0;
    logic        fifo_wr;
    logic [63:0] fifo_data;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    pxpk_assembler u_pxpk_assembler (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_eol(pix_eol),
        .pix_data(pix_data), .cfg_depth(cfg_depth), .cfg_display(cfg_display),
        .cfg_swap(cfg_swap), .fifo_wr(fifo_wr), .fifo_data(fifo_data)
    );

    // Word A: slot low bytes 01,02,03,04 ; word B: 05,06,07,08 (upper bytes are junk)
    localparam logic [63:0] WA  = 64'hAA04_BB03_CC02_DD01;
    localparam logic [63:0] WB  = 64'h1108_2207_3306_4405;
    localparam logic [63:0] WAS = 64'hBB03_AA04_DD01_CC02; // A with pairs exchanged

    typedef struct packed {
        logic        v;
        logic        e;
        logic        dep;
        logic        disp;
        logic        sw;
        logic [63:0] din;
        logic        xwr;
        logic [63:0] xdat;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b0, WA, 1'b1, WA,                     8'd2},  // R2 pass-through
        '{1'b0,1'b0,1'b1,1'b0,1'b0, WB, 1'b0, 64'h0,                  8'd10}, // R10 idle
        '{1'b1,1'b0,1'b0,1'b0,1'b0, WA, 1'b0, 64'h0,                  8'd4},  // R4 first half quiet
        '{1'b1,1'b0,1'b0,1'b0,1'b0, WB, 1'b1, 64'h0807060504030201,   8'd3},  // R3 pair packed
        '{1'b1,1'b0,1'b1,1'b1,1'b0, WA, 1'b0, 64'h0,                  8'd5},  // R5 display forces bytes
        '{1'b1,1'b0,1'b1,1'b1,1'b0, WB, 1'b1, 64'h0807060504030201,   8'd5},  // R5
        '{1'b1,1'b0,1'b1,1'b0,1'b1, WA, 1'b1, WAS,                    8'd6},  // R6 word swap
        '{1'b1,1'b0,1'b0,1'b0,1'b1, WA, 1'b0, 64'h0,                  8'd6},  // R6 byte swap
        '{1'b1,1'b0,1'b0,1'b0,1'b1, WB, 1'b1, 64'h07080506_03040102,  8'd6},  // R6
        '{1'b1,1'b1,1'b0,1'b0,1'b0, WA, 1'b1, 64'h00000000_04030201,  8'd7},  // R7 eol first half
        '{1'b1,1'b0,1'b0,1'b0,1'b0, WA, 1'b0, 64'h0,                  8'd4},  // R4
        '{1'b0,1'b1,1'b0,1'b0,1'b0, WB, 1'b1, 64'h00000000_04030201,  8'd8},  // R8 flush pending
        '{1'b0,1'b1,1'b0,1'b0,1'b0, WB, 1'b0, 64'h0,                  8'd8},  // R8 nothing pending
        '{1'b1,1'b0,1'b0,1'b0,1'b0, WB, 1'b0, 64'h0,                  8'd9},  // R9 fresh phase
        '{1'b1,1'b0,1'b0,1'b0,1'b0, WA, 1'b1, 64'h04030201_08070605,  8'd9},  // R9
        '{1'b1,1'b0,1'b0,1'b0,1'b0, WA, 1'b0, 64'h0,                  8'd4},  // R4
        '{1'b1,1'b1,1'b0,1'b0,1'b0, WB, 1'b1, 64'h0807060504030201,   8'd7}   // R7 eol on full word
    };

    task automatic check_wr(input logic exp, input int req);
        checks++;
        if (fifo_wr !== exp) begin
            failures++;
            $display("FAIL R%0d fifo_wr actual=%b expected=%b", req, fifo_wr, exp);
        end
    endtask

    task automatic check_data(input logic [63:0] exp, input int req);
        checks++;
        if (fifo_data !== exp) begin
            failures++;
            $display("FAIL R%0d fifo_data actual=%h expected=%h", req, fifo_data, exp);
        end
    endtask

    task automatic drive(input logic v, input logic e, input logic dep, input logic disp,
                         input logic sw, input logic [63:0] d);
        pix_valid = v; pix_eol = e; cfg_depth = dep; cfg_display = disp;
        cfg_swap = sw; pix_data = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_wr(1'b0, 1);              // R1 during reset
        // half word pending, then reset
        rst = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, WA);
        check_wr(1'b0, 4);              // R4
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, WA);
        check_wr(1'b0, 1);              // R1
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, WA);
        check_wr(1'b0, 1);              // R1 first cycle after reset

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].v, VEC[i].e, VEC[i].dep, VEC[i].disp, VEC[i].sw, VEC[i].din);
            check_wr(VEC[i].xwr, int'(VEC[i].req));
            if (VEC[i].xwr) check_data(VEC[i].xdat, int'(VEC[i].req));
        end

        // R1: half word pending at reset is lost; phase restarts at bits 31:0
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, WA);
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, WA);
        check_wr(1'b0, 1);
        rst = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, WB);
        check_wr(1'b0, 1);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, WA);
        check_wr(1'b1, 1);
        check_data(64'h04030201_08070605, 1);

        // R10: idle after a write produces nothing
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, WA);
        check_wr(1'b0, 10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule